// File: doc/BRIEF.md
# Super I/O configuration port controller

This block is the configuration front end of a multi-function I/O chip, sitting on a byte-wide host I/O bus. Two adjacent ports at `CFG_BASE` form an index/data pair. Configuration access stays closed until the host writes the open key 0x87 to the index port twice in a row. Writing the close key 0xAA to the index port shuts it again. While access is open, the host can:

- read the read-only manufacturer and chip identity bytes;
- pick a logical device through a select register;
- read and write that device's 16-bit base address, which is kept in a separate bank per device.

The base address of the hardware-monitor device (device 4) opens an aligned 8-byte I/O window. Inside that window, offset 5 holds a monitor index register and offset 6 passes data accesses through to the monitor function. The block produces the index and the read and write strobes. The monitor registers themselves are outside the block.

The key sequence is run by a three-state machine:

| State | Meaning | Transitions |
|-------|---------|-------------|
| `LK_CLOSED` | Access closed | Goes to `LK_HALF` on an index write of 0x87. |
| `LK_HALF` | One open key seen | Goes to `LK_OPEN` on a second index write of 0x87. Goes back to `LK_CLOSED` on an index write of any other byte, or on any write to the data port. |
| `LK_OPEN` | Access open | Goes to `LK_CLOSED` on an index write of 0xAA. Any other index write stays in `LK_OPEN` and loads the index register. |

Top module: `sio_cfg_ctrl`

## Requirements
- R1: After reset, access is closed, logical device 0 is selected, every base address and the configuration index are zero, the monitor index is zero, and `mon_en` is low.
- R2: `cfg_open` rises in the cycle after the second of two consecutive index-port (`CFG_BASE`) writes of 0x87, and not before.
- R3: In `LK_HALF`, an index write of any byte other than 0x87, or any write to the data port (`CFG_BASE`+1), returns the machine to `LK_CLOSED`. After that, two fresh 0x87 writes are needed to open access.
- R4: A single index-port write of 0xAA closes access from any state. `cfg_open` is low in the next cycle.
- R5: While access is not open, reads of either configuration port return 0xFF and writes to the data port change no register.
- R6: With access open, index 0x20 reads the chip ID high byte and 0x21 the low byte (`CHIP_ID`). Index 0x23 reads 0x19 and 0x24 reads 0x34. Writes to these four indexes are ignored.
- R7: Index 0x07 is the logical-device select and can be read and written. Index 0x60 (bits 15:8) and 0x61 (bits 7:0) read and write the base address of the selected device only. For a device number at or above `NUM_LDN`, these two indexes read 0x00 and ignore writes. Any other index reads 0x00.
- R8: The monitor window covers the 8 addresses whose bits 15:3 match bits 15:3 of device `MON_LDN`'s base. `mon_en` is high exactly when those base bits are nonzero. The window works whether configuration access is open or closed.
- R9: Inside the window, a write at offset 5 loads `mon_index`, and a read at offset 5 returns it. At offset 6, a read returns `mon_rdata` and pulses `mon_rd`, and a write pulses `mon_wr` with `mon_wdata` equal to the written byte. Every other offset, and every address outside both the window and the configuration ports, reads 0xFF.
- R10: When the window overlaps the configuration ports, the configuration ports take precedence: accesses to them produce no monitor strobe and no monitor read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per byte |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data for the addressed port (combinational) |
| cfg_open | output | 1 | Configuration access is open |
| mon_en | output | 1 | Monitor window is decoded |
| mon_index | output | 8 | Monitor index register |
| mon_wr | output | 1 | Write strobe to the monitor data register |
| mon_rd | output | 1 | Read strobe of the monitor data register |
| mon_wdata | output | 8 | Write data to the monitor |
| mon_rdata | input | 8 | Read data from the monitor |

## Verification
The bench builds the block with `CFG_BASE` = 0x2E, `NUM_LDN` = 8, `MON_LDN` = 4 and a non-default `CHIP_ID` of 0x0541. The non-default chip ID shows that the identity bytes follow the parameter and not a constant. Eight banks allow a device number above the bank range (9) to be selected, so the out-of-range read and write behaviour can be reached. The low configuration base allows a monitor base of 0x0028, which places the configuration ports at offsets 6 and 7 of the window and so exercises the precedence rule. A base of 0x0005 exercises the case where nonzero low bits are discarded and the window stays disabled.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
    localparam int IO_AW    = 16;
    localparam int WIN_BITS = 3;

    typedef enum logic [1:0] {
        LK_CLOSED = 2'd0,
        LK_HALF   = 2'd1,
        LK_OPEN   = 2'd2
    } lk_state_t;

    localparam logic [7:0] KEY_OPEN    = 8'h87;
    localparam logic [7:0] KEY_CLOSE   = 8'hAA;

    localparam logic [7:0] REG_LDN_SEL = 8'h07;
    localparam logic [7:0] REG_CHIP_HI = 8'h20;
    localparam logic [7:0] REG_CHIP_LO = 8'h21;
    localparam logic [7:0] REG_MFR_HI  = 8'h23;
    localparam logic [7:0] REG_MFR_LO  = 8'h24;
    localparam logic [7:0] REG_BASE_HI = 8'h60;
    localparam logic [7:0] REG_BASE_LO = 8'h61;

    localparam logic [15:0] MFR_ID     = 16'h1934;
    localparam logic [7:0]  BUS_IDLE   = 8'hFF;

    localparam logic [WIN_BITS-1:0] MON_OFS_IDX = 3'd5;
    localparam logic [WIN_BITS-1:0] MON_OFS_DAT = 3'd6;
endpackage

// File: rtl/sio_unlock_fsm.sv
module sio_unlock_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       dat_wr,
    input  logic [7:0] wdata,
    output logic       cfg_open,
    output logic       idx_load
);
    lk_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_CLOSED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_CLOSED: begin
                if (idx_wr && wdata == KEY_OPEN) state_d = LK_HALF;
            end
            LK_HALF: begin
                if (idx_wr)      state_d = (wdata == KEY_OPEN) ? LK_OPEN : LK_CLOSED;
                else if (dat_wr) state_d = LK_CLOSED;
            end
            LK_OPEN: begin
                if (idx_wr && wdata == KEY_CLOSE) state_d = LK_CLOSED;
            end
            default: state_d = LK_CLOSED;
        endcase
    end

    always_comb begin
        cfg_open = (state_q == LK_OPEN);
        idx_load = (state_q == LK_OPEN) && idx_wr && (wdata != KEY_CLOSE);
    end
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_cfg_pkg::*;
#(
    parameter int          NUM_LDN = 8,
    parameter int          MON_LDN = 4,
    parameter logic [15:0] CHIP_ID = 16'h0406
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_load,
    input  logic             dat_wr_en,
    input  logic [7:0]       wdata,
    output logic [7:0]       cur_index,
    output logic [7:0]       reg_rdata,
    output logic [IO_AW-1:0] mon_base
);
    localparam int LDN_W = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;

    logic [7:0]       index_q;
    logic [7:0]       ldn_q;
    logic             ldn_ok;
    logic [LDN_W-1:0] ldn_sel;
    logic [IO_AW-1:0] bank_base [NUM_LDN];
    logic [IO_AW-1:0] sel_base;

    assign ldn_ok  = (int'(ldn_q) < NUM_LDN);
    assign ldn_sel = ldn_q[LDN_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        index_q <= '0;
        else if (idx_load) index_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  ldn_q <= '0;
        else if (dat_wr_en && index_q == REG_LDN_SEL) ldn_q <= wdata;
    end

    for (genvar g = 0; g < NUM_LDN; g++) begin : g_bank
        logic             hit;
        logic [IO_AW-1:0] base_q;

        assign hit = dat_wr_en && ldn_ok && (ldn_sel == LDN_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q <= '0;
            end else if (hit) begin
                if (index_q == REG_BASE_HI)      base_q[15:8] <= wdata;
                else if (index_q == REG_BASE_LO) base_q[7:0]  <= wdata;
            end
        end

        assign bank_base[g] = base_q;
    end

    assign sel_base = ldn_ok ? bank_base[ldn_sel] : '0;
    assign mon_base = bank_base[MON_LDN];

    always_comb begin
        case (index_q)
            REG_LDN_SEL: reg_rdata = ldn_q;
            REG_CHIP_HI: reg_rdata = CHIP_ID[15:8];
            REG_CHIP_LO: reg_rdata = CHIP_ID[7:0];
            REG_MFR_HI:  reg_rdata = MFR_ID[15:8];
            REG_MFR_LO:  reg_rdata = MFR_ID[7:0];
            REG_BASE_HI: reg_rdata = sel_base[15:8];
            REG_BASE_LO: reg_rdata = sel_base[7:0];
            default:     reg_rdata = 8'h00;
        endcase
    end

    assign cur_index = index_q;
endmodule

// File: rtl/sio_mon_decode.sv
module sio_mon_decode
    import sio_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IO_AW-1:0] io_addr,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [7:0]       io_wdata,
    input  logic [IO_AW-1:0] mon_base,
    input  logic             cfg_port_hit,
    input  logic [7:0]       mon_rdata,
    output logic             mon_en,
    output logic             win_hit,
    output logic [7:0]       mon_index,
    output logic             mon_wr,
    output logic             mon_rd,
    output logic [7:0]       win_rdata
);
    logic [WIN_BITS-1:0] ofs;
    logic [7:0]          midx_q;

    assign ofs     = io_addr[WIN_BITS-1:0];
    assign mon_en  = |mon_base[IO_AW-1:WIN_BITS];
    assign win_hit = mon_en && !cfg_port_hit &&
                     (io_addr[IO_AW-1:WIN_BITS] == mon_base[IO_AW-1:WIN_BITS]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 midx_q <= '0;
        else if (io_wr && win_hit && ofs == MON_OFS_IDX) midx_q <= io_wdata;
    end

    always_comb begin
        mon_wr = io_wr && win_hit && (ofs == MON_OFS_DAT);
        mon_rd = io_rd && win_hit && (ofs == MON_OFS_DAT);
        if (ofs == MON_OFS_IDX)      win_rdata = midx_q;
        else if (ofs == MON_OFS_DAT) win_rdata = mon_rdata;
        else                         win_rdata = BUS_IDLE;
    end

    assign mon_index = midx_q;
endmodule

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] CFG_BASE = 16'h002E,
    parameter int          NUM_LDN  = 8,
    parameter int          MON_LDN  = 4,
    parameter logic [15:0] CHIP_ID  = 16'h0406
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    output logic        cfg_open,
    output logic        mon_en,
    output logic [7:0]  mon_index,
    output logic        mon_wr,
    output logic        mon_rd,
    output logic [7:0]  mon_wdata,
    input  logic [7:0]  mon_rdata
);
    logic             idx_hit, dat_hit;
    logic             idx_load;
    logic [7:0]       cur_index, reg_rdata, win_rdata;
    logic [IO_AW-1:0] mon_base;
    logic             win_hit;

    assign idx_hit = (io_addr == CFG_BASE);
    assign dat_hit = (io_addr == CFG_BASE + 16'd1);

    sio_unlock_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (io_wr && idx_hit),
        .dat_wr   (io_wr && dat_hit),
        .wdata    (io_wdata),
        .cfg_open (cfg_open),
        .idx_load (idx_load)
    );

    sio_cfg_regs #(
        .NUM_LDN (NUM_LDN),
        .MON_LDN (MON_LDN),
        .CHIP_ID (CHIP_ID)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_load  (idx_load),
        .dat_wr_en (cfg_open && io_wr && dat_hit),
        .wdata     (io_wdata),
        .cur_index (cur_index),
        .reg_rdata (reg_rdata),
        .mon_base  (mon_base)
    );

    sio_mon_decode u_mon (
        .clk          (clk),
        .rst_n        (rst_n),
        .io_addr      (io_addr),
        .io_wr        (io_wr),
        .io_rd        (io_rd),
        .io_wdata     (io_wdata),
        .mon_base     (mon_base),
        .cfg_port_hit (idx_hit || dat_hit),
        .mon_rdata    (mon_rdata),
        .mon_en       (mon_en),
        .win_hit      (win_hit),
        .mon_index    (mon_index),
        .mon_wr       (mon_wr),
        .mon_rd       (mon_rd),
        .win_rdata    (win_rdata)
    );

    assign mon_wdata = io_wdata;

    always_comb begin
        if (idx_hit)      io_rdata = cfg_open ? cur_index : BUS_IDLE;
        else if (dat_hit) io_rdata = cfg_open ? reg_rdata : BUS_IDLE;
        else if (win_hit) io_rdata = win_rdata;
        else              io_rdata = BUS_IDLE;
    end
endmodule

// File: rtl/sio_cfg_ctrl_chk.sv
module sio_cfg_ctrl_chk #(
    parameter logic [15:0] CFG_BASE = 16'h002E
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic        io_wr,
    input logic        io_rd,
    input logic [7:0]  io_wdata,
    input logic [7:0]  io_rdata,
    input logic        cfg_open,
    input logic        mon_en,
    input logic        mon_wr,
    input logic        mon_rd
);
    logic port_hit;
    assign port_hit = (io_addr == CFG_BASE) || (io_addr == CFG_BASE + 16'd1);

    p_open_after_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(io_wr && io_addr == CFG_BASE && io_wdata == 8'h87));

    p_close_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == CFG_BASE && io_wdata == 8'hAA) |=> !cfg_open);

    p_closed_reads_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && port_hit) |-> io_rdata == 8'hFF);

    p_strobe_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_wr || mon_rd) |-> mon_en);

    p_strobe_needs_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_wr |-> io_wr) and (mon_rd |-> io_rd));

    p_port_precedence_r10: assert property (@(posedge clk) disable iff (!rst_n)
        port_hit |-> (!mon_wr && !mon_rd));
endmodule

bind sio_cfg_ctrl sio_cfg_ctrl_chk #(.CFG_BASE(CFG_BASE)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .cfg_open (cfg_open),
    .mon_en   (mon_en),
    .mon_wr   (mon_wr),
    .mon_rd   (mon_rd)
);

// File: tb/sio_cfg_ctrl_tb_top.sv
module sio_cfg_ctrl_tb_top;
    localparam int TB_CHIP = 'h0541;
    localparam int CFG     = 'h2E;
    localparam int NLDN    = 8;
    localparam int MLDN    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0, mon_rdata = 8'h5A;
    logic [7:0]  io_rdata, mon_index, mon_wdata;
    logic        cfg_open, mon_en, mon_wr, mon_rd;

    int checks = 0;
    int errors = 0;

    int mstate = 0;
    int midx = 0;
    int mldn = 0;
    int mmidx = 0;
    int bank [NLDN];

    always #4 clk = ~clk;

    sio_cfg_ctrl #(
        .CFG_BASE (16'h002E),
        .NUM_LDN  (NLDN),
        .MON_LDN  (MLDN),
        .CHIP_ID  (16'h0541)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open), .mon_en(mon_en),
        .mon_index(mon_index), .mon_wr(mon_wr), .mon_rd(mon_rd), .mon_wdata(mon_wdata),
        .mon_rdata(mon_rdata)
    );

    function automatic int m_reg(int i);
        case (i)
            'h07: return mldn;
            'h20: return TB_CHIP / 256;
            'h21: return TB_CHIP % 256;
            'h23: return 'h19;
            'h24: return 'h34;
            'h60: return (mldn < NLDN) ? bank[mldn] / 256 : 0;
            'h61: return (mldn < NLDN) ? bank[mldn] % 256 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic int m_winbase();
        return bank[MLDN] & 'hFFF8;
    endfunction

    function automatic bit m_hit(int a);
        return m_winbase() != 0 && (a & 'hFFF8) == m_winbase() && a != CFG && a != CFG + 1;
    endfunction

    function automatic int m_rdata(int a);
        if (a == CFG)     return (mstate == 2) ? midx : 'hFF;
        if (a == CFG + 1) return (mstate == 2) ? m_reg(midx) : 'hFF;
        if (m_hit(a)) begin
            if ((a & 7) == 5) return mmidx;
            if ((a & 7) == 6) return int'(mon_rdata);
        end
        return 'hFF;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic m_update(int a, int d);
        if (a == CFG) begin
            case (mstate)
                0: if (d == 'h87) mstate = 1;
                1: mstate = (d == 'h87) ? 2 : 0;
                default: if (d == 'hAA) mstate = 0; else midx = d;
            endcase
        end else if (a == CFG + 1) begin
            if (mstate == 1) mstate = 0;
            else if (mstate == 2) begin
                if (midx == 'h07) mldn = d;
                else if (midx == 'h60 && mldn < NLDN) bank[mldn] = (bank[mldn] % 256) + d * 256;
                else if (midx == 'h61 && mldn < NLDN) bank[mldn] = (bank[mldn] & 'hFF00) + d;
            end
        end else if (m_hit(a) && (a & 7) == 5) begin
            mmidx = d;
        end
    endtask

    // One bus cycle; outputs compared against the model every clock.
    task automatic step(string tag, int a, bit wr, bit rd, int d);
        bit win6;
        io_addr = 16'(a); io_wr = wr; io_rd = rd; io_wdata = 8'(d);
        #1;
        win6 = m_hit(a) && (a & 7) == 6;
        chk(tag, "io_rdata", int'(io_rdata), m_rdata(a));
        chk(tag, "cfg_open", int'(cfg_open), int'(mstate == 2));
        chk(tag, "mon_en", int'(mon_en), int'(m_winbase() != 0));
        chk(tag, "mon_index", int'(mon_index), mmidx);
        chk(tag, "mon_wr", int'(mon_wr), int'(wr && win6));
        chk(tag, "mon_rd", int'(mon_rd), int'(rd && win6));
        if (wr && win6) chk(tag, "mon_wdata", int'(mon_wdata), d);
        @(posedge clk);
        if (wr) m_update(a, d);
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
    endtask

    task automatic wr(string tag, int a, int d); step(tag, a, 1'b1, 1'b0, d); endtask
    task automatic rd(string tag, int a);        step(tag, a, 1'b0, 1'b1, 0); endtask
    task automatic cfg_w(string tag, int i, int d); wr(tag, CFG, i); wr(tag, CFG + 1, d); endtask
    task automatic cfg_r(string tag, int i);        wr(tag, CFG, i); rd(tag, CFG + 1); endtask
    task automatic unlock(string tag);              wr(tag, CFG, 'h87); wr(tag, CFG, 'h87); endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired in every requirement check actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NLDN; i++) bank[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd("R1", CFG + 1);
        chk("R1", "cfg_open", int'(cfg_open), 0);
        chk("R1", "mon_en", int'(mon_en), 0);
        rd("R5", CFG);
        chk("R5", "closed index read", int'(io_rdata), 'hFF);

        // R5 data writes while closed are ignored
        wr("R5", CFG, 'h07);
        wr("R5", CFG + 1, 'h03);
        unlock("R2");
        chk("R2", "open after two keys", int'(cfg_open), 1);
        cfg_r("R5", 'h07);
        chk("R5", "ldn unchanged by closed write", int'(io_rdata), 0);

        // R4 close, R3 broken sequences
        wr("R4", CFG, 'hAA);
        chk("R4", "closed after key", int'(cfg_open), 0);
        wr("R3", CFG, 'h87);
        wr("R3", CFG, 'h55);
        wr("R3", CFG, 'h87);
        chk("R3", "other byte restarts", int'(cfg_open), 0);
        wr("R3", CFG + 1, 'h00);
        wr("R3", CFG, 'h87);
        chk("R3", "data write restarts", int'(cfg_open), 0);
        wr("R4", CFG, 'hAA);
        wr("R4", CFG, 'h87);
        wr("R4", CFG, 'hAA);
        wr("R4", CFG, 'h87);
        chk("R4", "close from half state", int'(cfg_open), 0);
        wr("R2", CFG, 'h87);
        chk("R2", "open after second key", int'(cfg_open), 1);

        // R6 identity bytes
        cfg_r("R6", 'h20); chk("R6", "chip hi", int'(io_rdata), 'h05);
        cfg_r("R6", 'h21); chk("R6", "chip lo", int'(io_rdata), 'h41);
        cfg_r("R6", 'h23); chk("R6", "mfr hi", int'(io_rdata), 'h19);
        cfg_r("R6", 'h24); chk("R6", "mfr lo", int'(io_rdata), 'h34);
        cfg_w("R6", 'h20, 'h00);
        rd("R6", CFG + 1); chk("R6", "chip hi read-only", int'(io_rdata), 'h05);

        // R7 banked base addresses
        cfg_w("R7", 'h07, 4);
        cfg_w("R7", 'h60, 'h12);
        cfg_w("R7", 'h61, 'h37);
        cfg_w("R7", 'h07, 2);
        cfg_w("R7", 'h60, 'hAB);
        cfg_r("R7", 'h60); chk("R7", "bank2 hi", int'(io_rdata), 'hAB);
        cfg_w("R7", 'h07, 4);
        cfg_r("R7", 'h60); chk("R7", "bank4 hi kept", int'(io_rdata), 'h12);
        cfg_r("R7", 'h61); chk("R7", "bank4 lo", int'(io_rdata), 'h37);
        cfg_w("R7", 'h07, 9);
        cfg_w("R7", 'h60, 'h77);
        cfg_r("R7", 'h60); chk("R7", "out of range bank", int'(io_rdata), 0);
        cfg_r("R7", 'h30); chk("R7", "unused index", int'(io_rdata), 0);
        cfg_w("R7", 'h07, 4);

        // R8 / R9 window at 0x1230 (low bits of 0x1237 ignored)
        chk("R8", "window enabled", int'(mon_en), 1);
        wr("R9", 'h1235, 'h44);
        rd("R9", 'h1235); chk("R9", "mon index read", int'(io_rdata), 'h44);
        mon_rdata = 8'hC3;
        rd("R9", 'h1236); chk("R9", "mon data read", int'(io_rdata), 'hC3);
        wr("R9", 'h1236, 'h9E);
        rd("R9", 'h1237);
        rd("R9", 'h1238); chk("R9", "outside window", int'(io_rdata), 'hFF);
        rd("R9", 'h1230);

        // R8 window independent of lock
        wr("R8", CFG, 'hAA);
        wr("R8", 'h1235, 'h21);
        rd("R8", 'h1236);
        rd("R5", CFG + 1);

        // R10 window overlapping the configuration ports
        unlock("R10");
        cfg_w("R10", 'h60, 'h00);
        cfg_w("R10", 'h61, 'h28);
        wr("R10", CFG, 'h07);
        rd("R10", CFG + 1);
        wr("R10", 'h2D, 'h66);
        rd("R10", 'h2D);
        rd("R10", 'h2F);

        // R8 nonzero low bits only: window disabled
        cfg_w("R8", 'h61, 'h05);
        chk("R8", "window disabled", int'(mon_en), 0);
        rd("R8", 'h0005);
        wr("R8", 'h0006, 'h11);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule